// File: doc/BRIEF.md
# Multi-format serial audio input deserializer

This block takes a three-wire serial audio stream (bit clock, word clock that selects left or right, serial data) and turns it back into parallel left and right samples. Three framings are accepted: I2S, left-justified and right-justified. They differ in which word-clock level marks the left channel and in how many bit periods after a word-clock change the MSB arrives. Samples may be 16, 18, 20 or 24 bits wide. Framing and width are static configuration inputs that are only changed while the block is held in reset.

All logic runs in a single system clock domain. The three serial lines pass through multi-flop synchronisers, and rising edges of the bit clock are detected in that domain. The system clock must run at least four times faster than the bit clock. Each recovered word leaves the block right-aligned and sign-extended on a 24-bit bus, with a one-cycle valid strobe and a channel flag. A half-frame that ends before the whole word has arrived is dropped and reported by a one-cycle error pulse.

Top module: `audio_serial_rx`

## Requirements
- R1: `cfg_width` selects the sample width: 2'b00 = 16, 2'b01 = 18, 2'b10 = 20 and 2'b11 = 24 bits.
- R2: Serial data and word-clock level are taken only at rising edges of the bit clock. Data that changes while the bit clock is low is received correctly.
- R3: With `cfg_mode` = 2'b01 (left-justified), word clock high marks the left channel. The MSB is the first bit after a word-clock change.
- R4: With `cfg_mode` = 2'b00 (I2S, the zero/reset encoding) or 2'b11, word clock low marks the left channel. The MSB is the second bit after a word-clock change.
- R5: With `cfg_mode` = 2'b10 (right-justified), word clock high marks the left channel. The MSB falls at bit position 32 minus the width, counting the first bit after the change as position 0, so the LSB is the last of 32 bits per half-frame.
- R6: Bits outside the active window of the current mode and width have no effect on the output word.
- R7: When the last bit of a word is captured, `smp_data` carries the word right-aligned and sign-extended to 24 bits, `smp_valid` is high for exactly one cycle, and `smp_right` is 1 for the right channel and 0 for the left.
- R8: A word-clock change that arrives before the current word is complete raises `frame_err` for one cycle. The partial word produces no `smp_valid`.
- R9: After reset, all outputs are zero. No word is output and no error is raised until the first word-clock change has been seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 2 | Framing: 00 I2S, 01 left-justified, 10 right-justified, 11 I2S |
| cfg_width | input | 2 | Sample width code (16/18/20/24) |
| ser_bclk | input | 1 | Serial bit clock, asynchronous |
| ser_wclk | input | 1 | Serial word clock, asynchronous |
| ser_data | input | 1 | Serial data, asynchronous |
| smp_data | output | 24 | Sign-extended, right-aligned sample |
| smp_valid | output | 1 | One-cycle strobe for a new sample |
| smp_right | output | 1 | Channel of the sample: 1 right, 0 left |
| frame_err | output | 1 | One-cycle pulse when a partial word is discarded |

## Verification
The hardest case to reach from the ports is a word-clock change in the middle of a word's window. A well-formed stream never produces it. The bench therefore truncates one left half-frame, sending only its window start plus half the sample width, and then continues with complete half-frames. It checks for exactly one error pulse, checks that no sample appears for the truncated word, and checks that the following words still decode. Every bit outside the window carries random junk, so any capture outside the window would corrupt a checked sample.

// File: rtl/asrx_pkg.sv
package asrx_pkg;

  typedef enum logic [1:0] {
    FMT_I2S     = 2'b00,
    FMT_LEFTJ   = 2'b01,
    FMT_RIGHTJ  = 2'b10,
    FMT_I2S_ALT = 2'b11
  } fmt_e;

  // Width code to number of sample bits.
  function automatic logic [7:0] width_bits(input logic [1:0] code);
    case (code)
      2'b00:   width_bits = 8'd16;
      2'b01:   width_bits = 8'd18;
      2'b10:   width_bits = 8'd20;
      default: width_bits = 8'd24;
    endcase
  endfunction

  // Bit position of the MSB after a word-clock change.
  function automatic logic [7:0] window_start(input logic [1:0] fmt,
                                              input logic [1:0] code,
                                              input logic [7:0] half_bits);
    case (fmt_e'(fmt))
      FMT_LEFTJ:  window_start = 8'd0;
      FMT_RIGHTJ: window_start = half_bits - width_bits(code);
      default:    window_start = 8'd1;
    endcase
  endfunction

  // Word-clock level that marks the left channel.
  function automatic logic left_level(input logic [1:0] fmt);
    left_level = (fmt == FMT_LEFTJ) || (fmt == FMT_RIGHTJ);
  endfunction

endpackage

// File: rtl/asrx_sync.sv
module asrx_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] d_sync
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= '0;
    else     stage_q[0] <= d_async;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[s] <= '0;
      else     stage_q[s] <= stage_q[s-1];
    end
  end

  assign d_sync = stage_q[STAGES-1];
endmodule

// File: rtl/asrx_frame.sv
module asrx_frame
  import asrx_pkg::*;
#(
  parameter int OUT_W     = 24,
  parameter int HALF_BITS = 32,
  localparam int CNT_W    = $clog2(2 * HALF_BITS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bclk_rise,
  input  logic             wclk,
  input  logic             sdata,
  input  logic [1:0]       fmt,
  input  logic [1:0]       wcode,
  output logic             word_done,
  output logic [OUT_W-1:0] word_raw,
  output logic             word_right,
  output logic             word_err
);
  localparam logic [CNT_W-1:0] POS_MAX = '1;

  logic [CNT_W-1:0] pos_q, got_q, pos_now, got_base;
  logic [CNT_W-1:0] wbits, wstart;
  logic             seen_q, locked_q, done_q, wclk_prev_q;
  logic             trans, locked_now, in_win, last_bit;
  logic [OUT_W-1:0] shift_q, shift_nxt;

  assign wbits  = CNT_W'(width_bits(wcode));
  assign wstart = CNT_W'(window_start(fmt, wcode, 8'(HALF_BITS)));

  always_comb begin
    trans      = seen_q && (wclk != wclk_prev_q);
    locked_now = locked_q || trans;
    if (trans)                pos_now = '0;
    else if (pos_q == POS_MAX) pos_now = POS_MAX;
    else                      pos_now = pos_q + 1'b1;
    got_base   = trans ? '0 : got_q;
    in_win     = locked_now && (pos_now >= wstart) && (pos_now < wstart + wbits);
    last_bit   = in_win && (pos_now == wstart + wbits - 1'b1);
    shift_nxt  = {shift_q[OUT_W-2:0], sdata};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q       <= '0;
      got_q       <= '0;
      seen_q      <= 1'b0;
      locked_q    <= 1'b0;
      done_q      <= 1'b0;
      wclk_prev_q <= 1'b0;
      shift_q     <= '0;
    end else if (bclk_rise) begin
      seen_q      <= 1'b1;
      wclk_prev_q <= wclk;
      pos_q       <= pos_now;
      locked_q    <= locked_now;
      got_q       <= in_win ? got_base + 1'b1 : got_base;
      done_q      <= last_bit ? 1'b1 : (trans ? 1'b0 : done_q);
      if (in_win) shift_q <= shift_nxt;
    end
  end

  assign word_done  = bclk_rise && last_bit;
  assign word_raw   = shift_nxt;
  assign word_right = (wclk != left_level(fmt));
  assign word_err   = bclk_rise && trans && locked_q && !done_q;

  // R5/R6: the closing bit is reached only after exactly width-1 window bits
  a_r5_full_window: assert property (@(posedge clk) disable iff (rst)
    word_done |-> (got_q == wbits - 1'b1));
  // R9: nothing leaves before a word-clock change has been seen
  a_r9_locked_first: assert property (@(posedge clk) disable iff (rst)
    word_done |-> locked_q);
  // R8: a discarded word never coincides with a completed one
  a_r8_err_excl: assert property (@(posedge clk) disable iff (rst)
    word_err |-> !word_done);
endmodule

// File: rtl/asrx_sext.sv
module asrx_sext
  import asrx_pkg::*;
#(
  parameter int OUT_W = 24
) (
  input  logic [OUT_W-1:0] raw,
  input  logic [1:0]       wcode,
  output logic [OUT_W-1:0] sext
);
  localparam int SH_W = $clog2(OUT_W + 1);
  logic [SH_W-1:0]         pad;
  logic signed [OUT_W-1:0] up;

  always_comb begin
    pad  = SH_W'(OUT_W) - SH_W'(width_bits(wcode));
    up   = raw << pad;
    sext = up >>> pad;
  end
endmodule

// File: rtl/audio_serial_rx.sv
module audio_serial_rx
  import asrx_pkg::*;
#(
  parameter int OUT_W       = 24,
  parameter int HALF_BITS   = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       cfg_mode,
  input  logic [1:0]       cfg_width,
  input  logic             ser_bclk,
  input  logic             ser_wclk,
  input  logic             ser_data,
  output logic [OUT_W-1:0] smp_data,
  output logic             smp_valid,
  output logic             smp_right,
  output logic             frame_err
);
  logic [2:0]       sync_q;
  logic             bclk_d_q, bclk_rise;
  logic             w_done, w_right, w_err;
  logic [OUT_W-1:0] w_raw, w_sext;

  asrx_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst),
    .d_async({ser_bclk, ser_wclk, ser_data}),
    .d_sync(sync_q)
  );

  always_ff @(posedge clk) begin
    if (rst) bclk_d_q <= 1'b0;
    else     bclk_d_q <= sync_q[2];
  end
  assign bclk_rise = sync_q[2] && !bclk_d_q;

  asrx_frame #(.OUT_W(OUT_W), .HALF_BITS(HALF_BITS)) u_frame (
    .clk(clk), .rst(rst), .bclk_rise(bclk_rise),
    .wclk(sync_q[1]), .sdata(sync_q[0]),
    .fmt(cfg_mode), .wcode(cfg_width),
    .word_done(w_done), .word_raw(w_raw),
    .word_right(w_right), .word_err(w_err)
  );

  asrx_sext #(.OUT_W(OUT_W)) u_sext (
    .raw(w_raw), .wcode(cfg_width), .sext(w_sext)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      smp_data  <= '0;
      smp_valid <= 1'b0;
      smp_right <= 1'b0;
      frame_err <= 1'b0;
    end else begin
      smp_valid <= w_done;
      frame_err <= w_err;
      if (w_done) begin
        smp_data  <= w_sext;
        smp_right <= w_right;
      end
    end
  end

  // Bits at and above the sign position must be all zero or all one.
  logic [OUT_W-1:0] sign_part, sign_ones;
  always_comb begin
    sign_part = smp_data >> (width_bits(cfg_width) - 8'd1);
    sign_ones = {OUT_W{1'b1}} >> (width_bits(cfg_width) - 8'd1);
  end

  // R7: sample strobe lasts one cycle
  a_r7_valid_pulse: assert property (@(posedge clk) disable iff (rst)
    smp_valid |=> !smp_valid);
  // R7: output is sign-extended from the configured width
  a_r7_sign_ext: assert property (@(posedge clk) disable iff (rst)
    smp_valid |-> (sign_part == '0 || sign_part == sign_ones));
  // R8: error strobe lasts one cycle
  a_r8_err_pulse: assert property (@(posedge clk) disable iff (rst)
    frame_err |=> !frame_err);
endmodule

// File: tb/audio_serial_rx_tb.sv
module audio_serial_rx_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_BCLK  = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  cfg_mode = 2'b00;
  logic [1:0]  cfg_width = 2'b00;
  logic        ser_bclk = 1'b0, ser_wclk = 1'b0, ser_data = 1'b0;
  logic [23:0] smp_data;
  logic        smp_valid, smp_right, frame_err;

  int checks = 0, fails = 0, err_seen = 0;
  logic [24:0] exp_q[$];
  string cur_tag = "R4";

  always #(CLK_PERIOD/2) clk = ~clk;

  audio_serial_rx u_dut (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_width(cfg_width),
    .ser_bclk(ser_bclk), .ser_wclk(ser_wclk), .ser_data(ser_data),
    .smp_data(smp_data), .smp_valid(smp_valid), .smp_right(smp_right),
    .frame_err(frame_err)
  );

  function automatic int wbits(input logic [1:0] c);
    case (c) 2'b00: return 16; 2'b01: return 18; 2'b10: return 20; default: return 24; endcase
  endfunction

  function automatic int wstart(input logic [1:0] m, input logic [1:0] c);
    if (m == 2'b01) return 0;
    if (m == 2'b10) return 32 - wbits(c);
    return 1;
  endfunction

  function automatic logic [23:0] sext(input logic [23:0] s, input int w);
    logic signed [23:0] t;
    t = s << (24 - w);
    return t >>> (24 - w);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Output monitor, sampled away from the active edge.
  always @(negedge clk) begin
    if (!rst && frame_err) err_seen++;
    if (!rst && smp_valid) begin
      if (exp_q.size() == 0) begin
        check({cur_tag, " R9 unexpected sample"}, {7'd0, smp_right, smp_data}, 32'hFFFF_FFFF);
      end else begin
        logic [24:0] e;
        e = exp_q.pop_front();
        check({cur_tag, " R7 sample/channel"}, {7'd0, smp_right, smp_data}, {7'd0, e});
      end
    end
  end

  task automatic send_bit(input logic w, input logic d);
    ser_bclk = 1'b0; ser_wclk = w; ser_data = d;
    repeat (HALF_BCLK) @(negedge clk);
    ser_bclk = 1'b1;
    repeat (HALF_BCLK) @(negedge clk);
  endtask

  // One half-frame; nbits < 32 truncates it, expect=0 pushes nothing.
  task automatic send_half(input logic right, input logic [23:0] s, input int nbits, input bit expect_out);
    int w, st;
    logic lvl;
    w   = wbits(cfg_width);
    st  = wstart(cfg_mode, cfg_width);
    lvl = (cfg_mode == 2'b01 || cfg_mode == 2'b10) ? ~right : right;
    if (expect_out) exp_q.push_back({right, sext(s, w)});
    for (int p = 0; p < nbits; p++) begin
      logic d;
      if (p >= st && p < st + w) d = s[w-1-(p-st)];
      else                       d = 1'($urandom);   // R6 junk outside window
      send_bit(lvl, d);
    end
  endtask

  task automatic run_config(input logic [1:0] m, input logic [1:0] c, input string tag, input int frames);
    int w;
    w = wbits(c);
    rst = 1'b1; cfg_mode = m; cfg_width = c; cur_tag = tag;
    ser_bclk = 1'b0; ser_wclk = 1'b0; ser_data = 1'b0;
    repeat (4) @(negedge clk);
    check("R9 reset outputs", {6'd0, smp_valid, smp_right, frame_err, smp_data}, 32'd0);
    rst = 1'b0;
    err_seen = 0;
    send_half(1'b1, 24'h0, 32, 1'b0);           // R9 preamble, no lock yet
    // directed extremes: most positive, most negative
    send_half(1'b0, (24'h1 << (w-1)) - 1, 32, 1'b1);
    send_half(1'b1, 24'h1 << (w-1), 32, 1'b1);
    for (int f = 0; f < frames; f++) begin
      send_half(1'b0, 24'($urandom) & ((24'h1 << w) - 1), 32, 1'b1);
      send_half(1'b1, 24'($urandom) & ((24'h1 << w) - 1), 32, 1'b1);
    end
    repeat (20) @(negedge clk);
    check({tag, " R7 all samples delivered"}, exp_q.size(), 0);
    check({tag, " R8 no spurious error"}, err_seen, 0);
    exp_q.delete();
  endtask

  task automatic run_short(input logic [1:0] m, input logic [1:0] c);
    int w;
    w = wbits(c);
    run_config(m, c, "R8", 1);
    err_seen = 0;
    send_half(1'b0, 24'h5A5A5A, wstart(m, c) + w/2, 1'b0);  // truncated
    send_half(1'b1, 24'h0A5A5A & ((24'h1 << w) - 1), 32, 1'b1);
    send_half(1'b0, 24'h03C3C3 & ((24'h1 << w) - 1), 32, 1'b1);
    repeat (20) @(negedge clk);
    check("R8 one error pulse", err_seen, 1);
    check("R8 partial word discarded", exp_q.size(), 0);
    exp_q.delete();
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int c = 0; c < 4; c++) begin
      run_config(2'b00, 2'(c), "R4 R1 R2", 4);
      run_config(2'b01, 2'(c), "R3 R1", 4);
      run_config(2'b10, 2'(c), "R5 R1 R6", 4);
    end
    run_config(2'b11, 2'b11, "R4 alt", 3);
    run_short(2'b01, 2'b00);
    run_short(2'b10, 2'b11);
    run_short(2'b00, 2'b10);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule